// File: doc/BRIEF.md
# Slew-Limited First-Order Sample Smoother

This block conditions a stream of signed 16-bit converted analog samples. Each accepted sample can first be held to a bounded change from an internally tracked value (a slew or ramp clamp). The clamped value then enters a first-order low-pass stage whose strength is set by a shift amount. A one-cycle strobe marks each incoming sample, and every sample produces exactly one filtered result with its own strobe one clock later.

An 8-bit configuration byte selects both settings. Its low three bits give the smoothing level; level 0 bypasses smoothing and the clamp entirely. Bits 6:4 give the clamp selector; selector 0 turns the clamp off. When the block leaves reset, or when either setting changes, the next sample seeds both the tracked value and the smoothed value directly. This keeps stale history from being mixed with a new configuration. Between samples all state is held.

Top module: `adc_slew_lpf`

## Requirements
- R1: While reset is applied and until the first sample is accepted, `out_vld` is 0 and `out_data` is 0.
- R2: The first sample accepted after reset is output unchanged.
- R3: The first sample accepted after a change in `cfg[2:0]` or `cfg[6:4]` is output unchanged, and it seeds both the tracked and the smoothed value.
- R4: With level `cfg[2:0]` = 0, every output equals its input sample, whatever the clamp selector is.
- R5: With level L = `cfg[2:0]` in 1..7, the smoothed value y is updated as y = y + ((r - y) >>> L), where >>> is an arithmetic shift and r is the clamped sample; the new y is the output.
- R6: With a non-zero level and selector n = `cfg[6:4]` in 1..7, the step limit is 32767 >> n (n = 4 gives 2047). A sample whose difference from the tracked value exceeds that limit is replaced by the tracked value plus or minus the limit, and the result becomes the new tracked value.
- R7: Selector 0 applies no clamp, so a jump such as 8000 to 16000 reaches the smoothing stage in full.
- R8: Bits 3 and 7 of `cfg` have no effect; changing them alone neither reseeds the state nor alters any result.
- R9: `out_vld` pulses high in the cycle after each `smp_vld` cycle and at no other time. `out_data` changes only when `out_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 16 | Signed two's-complement sample |
| cfg | input | 8 | Level in bits 2:0, clamp selector in bits 6:4, other bits unused |
| out_vld | output | 1 | Result strobe |
| out_data | output | 16 | Signed smoothed sample |

## Verification
Each result is due in the cycle after its input strobe, because only one register stage lies between input and output. The bench drives a sample at a falling edge and samples `out_vld` and `out_data` at the next falling edge. This keeps every comparison clear of the capturing edge. In idle gaps it checks that the strobe stays low and the data holds. A reference model in the bench handles clamping, smoothing and reseeding. It advances exactly once per driven sample, so expected values stay aligned with the single-cycle latency over random gaps and random configuration changes.

// File: rtl/adc_slew_lpf_pkg.sv
package adc_slew_lpf_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned RAMP_W = 3;

  typedef struct packed {
    logic [RAMP_W-1:0] ramp;
    logic [LVL_W-1:0]  lvl;
  } cfg_t;
endpackage

// File: rtl/adc_slew_cfg_dec.sv
module adc_slew_cfg_dec
  import adc_slew_lpf_pkg::*;
#(
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned LVL_LSB  = 0,
  parameter int unsigned RAMP_LSB = 4
) (
  input  logic [CFG_W-1:0] cfg_raw,
  output cfg_t             cfg_dec
);
  // Only the two fields are extracted; unused bits never reach state.
  always_comb begin
    cfg_dec.lvl  = cfg_raw[LVL_LSB  +: LVL_W];
    cfg_dec.ramp = cfg_raw[RAMP_LSB +: RAMP_W];
  end
endmodule

// File: rtl/adc_slew_clamp.sv
module adc_slew_clamp
  import adc_slew_lpf_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              en,
  input  logic [RAMP_W-1:0] sel,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] trk,
  output logic signed [DW-1:0] r
);
  localparam logic [DW-1:0] FULL = {1'b0, {(DW-1){1'b1}}};

  logic signed [DW:0] diff;
  logic signed [DW:0] lim;
  logic signed [DW:0] trk_x;
  logic signed [DW:0] up;
  logic signed [DW:0] dn;

  always_comb begin
    trk_x = {trk[DW-1], trk};
    diff  = {x[DW-1], x} - trk_x;
    lim   = {1'b0, FULL >> sel};
    up    = trk_x + lim;
    dn    = trk_x - lim;
    r     = x;
    if (en) begin
      if (diff > lim)       r = up[DW-1:0];
      else if (diff < -lim) r = dn[DW-1:0];
    end
  end
endmodule

// File: rtl/adc_slew_lpf_stage.sv
module adc_slew_lpf_stage
  import adc_slew_lpf_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [LVL_W-1:0]     lvl,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  output logic signed [DW-1:0] y_nxt
);
  localparam int unsigned NLVL = 1 << LVL_W;

  logic signed [DW:0] err;
  logic signed [DW:0] shifted [NLVL];
  logic signed [DW:0] sum;

  assign err = {x[DW-1], x} - {y[DW-1], y};

  // One arithmetic-shift candidate per level; the level picks one.
  for (genvar l = 0; l < NLVL; l++) begin : g_shift
    assign shifted[l] = err >>> l;
  end

  always_comb begin
    sum   = {y[DW-1], y} + shifted[lvl];
    y_nxt = sum[DW-1:0];
  end
endmodule

// File: rtl/adc_slew_lpf.sv
module adc_slew_lpf
  import adc_slew_lpf_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned LVL_LSB  = 0,
  parameter int unsigned RAMP_LSB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_data,
  input  logic [CFG_W-1:0]     cfg,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_data
);
  // Reset: asserted asynchronously, released after two clocks.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cfg_t cfg_d;
  cfg_t cfg_q, cfg_n;
  logic primed_q, primed_n;
  logic signed [DW-1:0] trk_q, trk_n;
  logic signed [DW-1:0] filt_q, filt_n;
  logic signed [DW-1:0] out_q, out_n;
  logic vld_q;

  logic reload;
  logic bypass;
  logic clamp_en;
  logic signed [DW-1:0] clamped;
  logic signed [DW-1:0] smoothed;

  adc_slew_cfg_dec #(
    .CFG_W(CFG_W), .LVL_LSB(LVL_LSB), .RAMP_LSB(RAMP_LSB)
  ) u_dec (
    .cfg_raw (cfg),
    .cfg_dec (cfg_d)
  );

  adc_slew_clamp #(.DW(DW)) u_clamp (
    .en  (clamp_en),
    .sel (cfg_d.ramp),
    .x   (smp_data),
    .trk (trk_q),
    .r   (clamped)
  );

  adc_slew_lpf_stage #(.DW(DW)) u_lpf (
    .lvl   (cfg_d.lvl),
    .x     (clamped),
    .y     (filt_q),
    .y_nxt (smoothed)
  );

  always_comb begin
    reload   = !primed_q || (cfg_d != cfg_q);
    bypass   = (cfg_d.lvl == '0);
    clamp_en = !bypass && (cfg_d.ramp != '0);

    primed_n = 1'b1;
    cfg_n    = cfg_d;
    if (reload || bypass) begin
      trk_n  = smp_data;
      filt_n = smp_data;
      out_n  = smp_data;
    end else begin
      trk_n  = clamped;
      filt_n = smoothed;
      out_n  = smoothed;
    end
  end

  // State advances only on an accepted sample (explicit clock enable).
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      primed_q <= 1'b0;
      cfg_q    <= '0;
      trk_q    <= '0;
      filt_q   <= '0;
      out_q    <= '0;
    end else if (smp_vld) begin
      primed_q <= primed_n;
      cfg_q    <= cfg_n;
      trk_q    <= trk_n;
      filt_q   <= filt_n;
      out_q    <= out_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= smp_vld;
  end

  assign out_vld  = vld_q;
  assign out_data = out_q;
endmodule

// File: rtl/adc_slew_lpf_chk.sv
module adc_slew_lpf_chk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CFG_W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [DW-1:0] smp_data,
  input logic [CFG_W-1:0] cfg,
  input logic          out_vld,
  input logic [DW-1:0] out_data
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen <= 1'b0;
    else if (out_vld) seen <= 1'b1;
  end

  a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !out_vld);

  a_r9_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_data));

  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(cfg[2:0]) == 3'd0) |-> out_data == $past(smp_data));

  a_r2_first_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !seen) |-> out_data == $past(smp_data));
endmodule

bind adc_slew_lpf adc_slew_lpf_chk #(.DW(DW), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .smp_vld  (smp_vld),
  .smp_data (smp_data),
  .cfg      (cfg),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/adc_slew_lpf_bench.sv
module adc_slew_lpf_bench;
  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic signed [15:0] smp_data;
  logic [7:0]  cfg;
  logic        out_vld;
  logic signed [15:0] out_data;

  int n_chk;
  int n_bad;
  bit done;

  // Reference model state
  bit m_primed;
  int m_cfg;
  int m_trk;
  int m_filt;
  int m_out;

  adc_slew_lpf u_adc_slew_lpf (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .cfg(cfg), .out_vld(out_vld), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_step(input int x, input int c);
    int lvl, rs, eff, r, d, lim;
    lvl = c & 7;
    rs  = (c >> 4) & 7;
    eff = c & 8'h77;
    if (!m_primed || eff != m_cfg || lvl == 0) begin
      m_trk = x; m_filt = x;
    end else begin
      r = x;
      if (rs != 0) begin
        lim = 32767 >> rs;
        d = x - m_trk;
        if (d > lim) r = m_trk + lim;
        else if (d < -lim) r = m_trk - lim;
      end
      m_trk = r;
      m_filt = m_filt + ((r - m_filt) >>> lvl);
    end
    m_primed = 1'b1;
    m_cfg = eff;
    m_out = m_filt;
    return m_filt;
  endfunction

  // Drive one sample at a falling edge, check one edge later.
  task automatic send(input int x, input int c, input string tag);
    int exp;
    smp_vld  = 1'b1;
    smp_data = 16'(x);
    cfg      = 8'(c);
    exp = model_step(x, c);
    @(negedge clk);
    smp_vld = 1'b0;
    check({tag, " strobe"}, int'(out_vld), 1);
    check(tag, int'(out_data), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R9 idle strobe", int'(out_vld), 0);
      check("R9 idle hold", int'(out_data), m_out);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    m_primed = 1'b0; m_cfg = 0; m_trk = 0; m_filt = 0; m_out = 0;
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; cfg = '0;
    repeat (3) @(negedge clk);
    check("R1 reset strobe", int'(out_vld), 0);
    check("R1 reset data", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 post-reset data", int'(out_data), 0);

    // R2: first sample raw even with strong smoothing and clamp
    send(8000, 8'h47, "R2 first raw");
    check("R2 value", int'(out_data), 8000);
    idle(2);

    // R6: level 2, selector 4: jump 8000 -> 16000 clamped to 2047 steps
    send(8000, 8'h42, "R3 reseed on cfg change");
    check("R3 value", int'(out_data), 8000);
    send(16000, 8'h42, "R6 clamp step");
    check("R6 clamp value", int'(out_data), 8000 + ((10047 - 8000) >>> 2));
    send(16000, 8'h42, "R6 clamp second");
    send(-30000, 8'h42, "R6 clamp negative");

    // R7: selector 0, level 2: unclamped jump
    send(8000, 8'h02, "R3 reseed");
    send(16000, 8'h02, "R7 no clamp");
    check("R7 value", int'(out_data), 10000);

    // R8: bits 3 and 7 toggled, no reseed
    send(16000, 8'h8A, "R8 unused bits");
    check("R8 value", int'(out_data), 10000 + (6000 >>> 2));
    send(16000, 8'h02, "R8 unused bits back");

    // R4: level 0 passthrough with clamp selector set
    send(-32768, 8'h70, "R4 bypass");
    send(32767, 8'h70, "R4 bypass max");
    check("R4 value", int'(out_data), 32767);
    idle(1);

    // R5: level 7, negative arithmetic shift
    send(0, 8'h07, "R3 reseed");
    send(-1000, 8'h07, "R5 negative shift");
    check("R5 value", int'(out_data), -8);
    send(32767, 8'h01, "R3 reseed lvl1");
    send(-32768, 8'h01, "R5 full swing");

    // Random mix
    begin
      int c;
      int unsigned seed;
      seed = $urandom(32'd20240611);
      c = 8'h42;
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(0, 15) == 0) c = $urandom_range(0, 255);
        else if ($urandom_range(0, 15) == 0) c = c ^ 8'h88;
        send($signed(16'($urandom)) , c, "R5 random");
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule